// File: doc/BRIEF.md
# Fixed-Latency Line Memory

A main-memory model for one port that keeps its contents as lines of four 32-bit words. Each cycle a requester may present its identity, a word address and either a single-word write or a read of a whole line. The memory answers every cycle with a response code of OK or WAIT. Every access costs a fixed number of cycles, and those cycles are counted down by an internal timer.

The memory is held by one requester at a time. When it is free, the first requester that presents a request takes it, and it stays with that requester until the timer runs out. Requests from other identities are refused with WAIT in the meantime. A stall input from the level below freezes the countdown. This models a memory that is itself held up by something further down.

Top module: `line_mem`

## Requirements
- R1: A word address splits into a line index (address bits above bit 1) and a word slot (address bits [1:0]). A write to address 4*L+k changes only slot k of line L.
- R2: `rdata_o` always shows the whole line selected by `req_addr_i`, with slot k at bits [32k+31:32k]. A read that is answered OK returns that line.
- R3: While the memory is free, the first request with a nonzero identity claims it. Until it is released, a request from any other identity gets WAIT, and the holder does not change.
- R4: The holder gets WAIT while the remaining count is nonzero. When the count is zero it gets OK (code 0), and a write is stored at that clock edge.
- R5: At a clock edge where the count is zero, the count reloads to `LATENCY` and the memory is released, whether or not the access was taken. At any other edge the count drops by one only while a holder exists and the stall flag is clear.
- R6: The stall flag is `lower_wait_i` registered once. While the flag is set, a nonzero count holds its value.
- R7: Reset sets the count to `LATENCY`, frees the memory, clears the stall flag and zeroes every stored word. With no request, the response is WAIT (code 1).
- R8: With `LATENCY` = 0, every request from the holder is answered OK in the cycle it is presented. A write is readable in the next cycle.
- R9: A refused request changes neither the stored contents nor the holder's timing.
- R10: Identity 0 means no requester. A request carrying identity 0 never claims the memory, always gets WAIT and never writes. Identities 1 to 3 are ordinary requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_id_i | input | 2 | Requester identity (0 = none) |
| req_write_i | input | 1 | 1 = write one word, 0 = read a line |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 32 | Word to write |
| lower_wait_i | input | 1 | The level below is stalling this memory |
| rsp_o | output | 2 | Response code: 0 = OK, 1 = WAIT |
| rdata_o | output | 128 | Line containing `req_addr_i` |

## Verification
Responses and the read line are combinational, so they are due in the same cycle as the request that causes them. A written word shows on `rdata_o` one cycle after its OK. A change on `lower_wait_i` affects the countdown one edge later, because it passes through the stall flag. The bench drives every request at a falling edge and samples the outputs 8 ns later, before the next rising edge. The expected OK cycle is computed by counting edges from the claim, plus one edge for each cycle the stall flag was set.

// File: rtl/line_mem_pkg.sv
package line_mem_pkg;
  localparam int WORD_W = 32;
  localparam int LINE_WORDS = 4;

  typedef enum logic [1:0] {
    ID_NONE  = 2'd0,
    ID_CACHE = 2'd1,
    ID_EXT   = 2'd2,
    ID_RSVD  = 2'd3
  } req_id_e;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_WAIT    = 2'd1,
    RSP_BLOCKED = 2'd2
  } rsp_e;
endpackage

// File: rtl/lm_owner.sv
module lm_owner
  import line_mem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_id_i,
  input  logic       release_i,
  output logic [1:0] own_q_o,
  output logic [1:0] own_cur_o,
  output logic       granted_o
);
  logic [1:0] own_q;
  logic       claim;

  assign claim     = (own_q == ID_NONE) && req_valid_i && (req_id_i != ID_NONE);
  assign own_cur_o = claim ? req_id_i : own_q;
  assign granted_o = req_valid_i && (req_id_i != ID_NONE) && (req_id_i == own_cur_o);
  assign own_q_o   = own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        own_q <= ID_NONE;
    else if (release_i) own_q <= ID_NONE;
    else                own_q <= own_cur_o;
  end
endmodule

// File: rtl/lm_timer.sv
module lm_timer #(
  parameter int LATENCY = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             lower_wait_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             wait_q_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY);

  logic [CNT_W-1:0] cnt_q;
  logic             wait_q;

  assign zero_o   = (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign wait_q_o = wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RELOAD;
      wait_q <= 1'b0;
    end else begin
      wait_q <= lower_wait_i;
      if (zero_o)                  cnt_q <= RELOAD;
      else if (active_i && !wait_q) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lm_array.sv
module lm_array #(
  parameter int LINES      = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINE_W     = 4,
  parameter int OFS_W      = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [LINE_W-1:0]            line_i,
  input  logic [OFS_W-1:0]             slot_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [LINE_WORDS*WORD_W-1:0] rdata_o
);
  logic [LINES-1:0][LINE_WORDS*WORD_W-1:0] mem_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar s = 0; s < LINE_WORDS; s++) begin : g_slot
      logic hit;
      assign hit = we_i && (line_i == LINE_W'(l)) && (slot_i == OFS_W'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  mem_q[l][s*WORD_W +: WORD_W] <= '0;
        else if (hit) mem_q[l][s*WORD_W +: WORD_W] <= wdata_i;
      end
    end
  end

  // out-of-range lines read as zero
  assign rdata_o = (int'(line_i) < LINES) ? mem_q[line_i] : '0;
endmodule

// File: rtl/line_mem.sv
module line_mem
  import line_mem_pkg::*;
#(
  parameter int LINES   = 16,
  parameter int LATENCY = 2,
  parameter int ADDR_W  = $clog2(LINES * LINE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [1:0]                   req_id_i,
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [WORD_W-1:0]            req_wdata_i,
  input  logic                         lower_wait_i,
  output logic [1:0]                   rsp_o,
  output logic [LINE_WORDS*WORD_W-1:0] rdata_o
);
  localparam int OFS_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1);

  logic [1:0]       own_q_w, own_cur_w;
  logic             granted_w, zero_w, wait_w, done_w;
  logic [CNT_W-1:0] cnt_w;

  lm_owner i_owner (
    .clk_i,
    .rst_ni,
    .req_valid_i,
    .req_id_i,
    .release_i (zero_w),
    .own_q_o   (own_q_w),
    .own_cur_o (own_cur_w),
    .granted_o (granted_w)
  );

  lm_timer #(.LATENCY(LATENCY), .CNT_W(CNT_W)) i_timer (
    .clk_i,
    .rst_ni,
    .active_i     (own_cur_w != ID_NONE),
    .lower_wait_i,
    .cnt_o        (cnt_w),
    .zero_o       (zero_w),
    .wait_q_o     (wait_w)
  );

  assign done_w = granted_w && zero_w;
  assign rsp_o  = done_w ? RSP_OK : RSP_WAIT;

  lm_array #(
    .LINES(LINES), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
    .LINE_W(LINE_W), .OFS_W(OFS_W)
  ) i_array (
    .clk_i,
    .rst_ni,
    .we_i    (done_w && req_write_i),
    .line_i  (req_addr_i[ADDR_W-1:OFS_W]),
    .slot_i  (req_addr_i[OFS_W-1:0]),
    .wdata_i (req_wdata_i),
    .rdata_o
  );
endmodule

// File: rtl/line_mem_chk.sv
module line_mem_chk #(
  parameter int LATENCY = 2,
  parameter int CNT_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_id_i,
  input logic [1:0]       rsp_o,
  input logic [1:0]       own_q,
  input logic [CNT_W-1:0] cnt,
  input logic             wait_q
);
  p_refuse_other_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && own_q != 2'd0 && req_id_i != own_q) |-> rsp_o == 2'd1);

  p_hold_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q != 2'd0 && cnt != '0) |=> own_q == $past(own_q));

  p_ok_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_o == 2'd0) |-> cnt == '0);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> (cnt == CNT_W'(LATENCY) && own_q == 2'd0));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0 && wait_q) |=> cnt == $past(cnt));

  p_null_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_id_i == 2'd0) |-> rsp_o == 2'd1);
endmodule

bind line_mem line_mem_chk #(.LATENCY(LATENCY), .CNT_W(CNT_W)) i_chk (
  .clk_i,
  .rst_ni,
  .req_valid_i,
  .req_id_i,
  .rsp_o,
  .own_q  (own_q_w),
  .cnt    (cnt_w),
  .wait_q (wait_w)
);

// File: tb/test_line_mem.sv
module test_line_mem;
  localparam int ADDR_W = 6;
  localparam logic [1:0] OK = 2'd0, WT = 2'd1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 0, req_write = 0, lower_wait = 0;
  logic [1:0]        req_id = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic [31:0]       wdata = 0;
  logic [1:0]        rsp_a, rsp_z;
  logic [127:0]      line_a, line_z;

  line_mem #(.LINES(16), .LATENCY(2)) i_line_mem (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_id_i(req_id),
    .req_write_i(req_write), .req_addr_i(addr), .req_wdata_i(wdata),
    .lower_wait_i(lower_wait), .rsp_o(rsp_a), .rdata_o(line_a));

  line_mem #(.LINES(16), .LATENCY(0)) i_line_mem_z (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_id_i(req_id),
    .req_write_i(req_write), .req_addr_i(addr), .req_wdata_i(wdata),
    .lower_wait_i(lower_wait), .rsp_o(rsp_z), .rdata_o(line_z));

  typedef struct {
    bit           use_z;
    logic [1:0]   rsp;
    bit           chk_line;
    logic [127:0] line;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;

  task automatic step(bit v, logic [1:0] id, bit we, int a, logic [31:0] d, bit lw,
                      bit push, bit uz, logic [1:0] er, bit cl, logic [127:0] el,
                      string tag);
    item_t it;
    @(negedge clk);
    req_valid = v; req_id = id; req_write = we; addr = ADDR_W'(a);
    wdata = d; lower_wait = lw;
    if (push) begin
      it.use_z = uz; it.rsp = er; it.chk_line = cl; it.line = el; it.tag = tag;
      q.push_back(it);
    end
  endtask

  // monitor: sample 8 ns after the falling edge, before the rising edge
  initial forever begin
    @(negedge clk);
    #8;
    if (q.size() > 0) begin
      item_t it;
      logic [1:0]   r;
      logic [127:0] l;
      it = q.pop_front();
      r = it.use_z ? rsp_z : rsp_a;
      l = it.use_z ? line_z : line_a;
      checks++;
      if (r !== it.rsp) begin
        fails++;
        $display("FAIL %s rsp actual=%0d expected=%0d", it.tag, r, it.rsp);
      end
      if (it.chk_line) begin
        checks++;
        if (l !== it.line) begin
          fails++;
          $display("FAIL %s line actual=%h expected=%h", it.tag, l, it.line);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R7: reset state, no request
    step(0, 0, 0, 5, 0, 0, 1, 0, WT, 1, '0, "R7 reset A");
    step(0, 0, 0, 5, 0, 0, 1, 1, WT, 1, '0, "R7 reset Z");
    // R4, R1: write addr 5 (line 1 slot 1)
    step(1, 2, 1, 5, 32'hAAAA0001, 0, 1, 0, WT, 0, '0, "R4 claim wait");
    step(1, 2, 1, 5, 32'hAAAA0001, 0, 1, 0, WT, 0, '0, "R4 count wait");
    step(1, 2, 1, 5, 32'hAAAA0001, 0, 1, 0, OK, 0, '0, "R4 ok at zero");
    // R2, R1: read line 1
    step(1, 2, 0, 4, 0, 0, 1, 0, WT, 0, '0, "R2 read wait");
    step(1, 2, 0, 4, 0, 0, 1, 0, WT, 0, '0, "R2 read wait");
    step(1, 2, 0, 4, 0, 0, 1, 0, OK, 1, {32'h0, 32'h0, 32'hAAAA0001, 32'h0}, "R2 R1 line");
    // R3, R9: id1 holds, id2 refused
    step(1, 1, 0, 4, 0, 0, 1, 0, WT, 0, '0, "R3 claim id1");
    step(1, 2, 1, 4, 32'hBBBB0000, 0, 1, 0, WT, 0, '0, "R3 other refused");
    step(1, 1, 0, 4, 0, 0, 1, 0, OK, 1, {32'h0, 32'h0, 32'hAAAA0001, 32'h0}, "R9 no change");
    // R6: stall for two cycles
    step(1, 1, 1, 9, 32'h12345678, 1, 1, 0, WT, 0, '0, "R6 claim");
    step(1, 1, 1, 9, 32'h12345678, 1, 1, 0, WT, 0, '0, "R6 stalled");
    step(1, 1, 1, 9, 32'h12345678, 0, 1, 0, WT, 0, '0, "R6 frozen");
    step(1, 1, 1, 9, 32'h12345678, 0, 1, 0, WT, 0, '0, "R6 frozen");
    step(1, 1, 1, 9, 32'h12345678, 0, 1, 0, OK, 0, '0, "R6 late ok");
    step(1, 1, 0, 8, 0, 0, 1, 0, WT, 0, '0, "R1 read line 2");
    step(1, 1, 0, 8, 0, 0, 1, 0, WT, 0, '0, "R1 read line 2");
    step(1, 1, 0, 8, 0, 0, 1, 0, OK, 1, {32'h0, 32'h0, 32'h12345678, 32'h0}, "R1 slot 1");
    // R5: holder leaves, memory released at zero
    step(1, 2, 0, 0, 0, 0, 1, 0, WT, 0, '0, "R5 claim id2");
    step(0, 0, 0, 0, 0, 0, 0, 0, WT, 0, '0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, WT, 0, '0, "");
    step(1, 1, 0, 0, 0, 0, 1, 0, WT, 0, '0, "R5 new claim");
    step(1, 1, 0, 0, 0, 0, 1, 0, WT, 0, '0, "R5 new claim");
    step(1, 1, 0, 0, 0, 0, 1, 0, OK, 0, '0, "R5 released");
    // R10: identity 0 never claims or writes
    for (int i = 0; i < 4; i++)
      step(1, 0, 1, 0, 32'hDEAD0000, 0, 1, 0, WT, 0, '0, "R10 null id");
    step(1, 1, 0, 0, 0, 0, 1, 0, WT, 0, '0, "R10 read");
    step(1, 1, 0, 0, 0, 0, 1, 0, WT, 0, '0, "R10 read");
    step(1, 1, 0, 0, 0, 0, 1, 0, OK, 1, '0, "R10 no write");
    // R8: zero latency
    step(1, 2, 1, 46, 32'hCAFE0002, 0, 1, 1, OK, 0, '0, "R8 write ok");
    step(1, 1, 0, 44, 0, 0, 1, 1, OK, 1, {32'h0, 32'hCAFE0002, 32'h0, 32'h0}, "R8 R2 read ok");
    step(1, 3, 1, 47, 32'h00000033, 0, 1, 1, OK, 0, '0, "R8 id3 ok");
    step(1, 1, 0, 44, 0, 0, 1, 1, OK, 1, {32'h00000033, 32'hCAFE0002, 32'h0, 32'h0}, "R8 R1 slot 3");
    step(0, 0, 0, 0, 0, 0, 0, 0, WT, 0, '0, "");
    wait (q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule